// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the serial core of a synchronous serial port working as bus master. It takes words from an external transmit FIFO through a pop strobe, shifts each one out most significant bit first on the serial clock and data-out pins while it samples the data-in pin, and hands the captured word to an external receive FIFO through a push strobe. It produces exactly one received word for each transmitted word. The word size, the clock prescale and the loopback choice are captured when a word is popped and are held until that word completes.

The serial clock idles low. Outgoing data changes while the clock is low and is sampled on the rising edge. Each half-period of the clock lasts `prescale + 1` system clocks. Chip select is active low. It falls one half-period before the first rising edge and stays low across words that follow each other directly. It rises once the last word of a burst completes. In loopback the outgoing bits feed the receive shift register directly and every pin stays idle. The engine never starts a word that could overflow the receive FIFO. A request for slave operation is flagged as an error and blocks every transfer.

Top module: `spi_xfer_engine`

## Requirements
- R1: After synchronous reset, cs_n is 1, and sck, mosi, busy, tx_pop, rx_push and mode_err are all 0.
- R2: While enable is 0, no word is popped, busy stays 0, and queued transmit words stay in the transmit FIFO.
- R3: A word starts (tx_pop = 1) only if tx_valid is 1 and rx_level is below RX_DEPTH. When a word is pushed in the same cycle, the start instead requires rx_level below RX_DEPTH - 1. rx_push therefore never occurs while the receive FIFO holds RX_DEPTH entries.
- R4: For a word started with loopback = 1, rx_data equals the transmitted word masked to the word size, and throughout that word sck = 0, mosi = 0 and cs_n = 1.
- R5: The received word is masked to N = word_bits_m1 + 1 bits (1 to 16). Bits N and above of rx_data are 0, and only bits N-1..0 of tx_data are sent.
- R6: Transmit words are sent in FIFO order, and each pop is followed by exactly one push carrying that word's received value, with the first sampled bit in bit N-1.
- R7: While enable and slave_req are both 1, no word is popped, and mode_err is 1 in the following cycle (mode_err is the registered value of enable AND slave_req).
- R8: The sck half-period is prescale + 1 clocks and sck idles low. mosi holds bit N-1-k of the word at the k-th rising edge of that word (k from 0), and mosi is 0 when no word is active.
- R9: cs_n falls in the cycle after the pop, and the first sck rise comes prescale + 1 cycles after that. cs_n stays low between words that follow each other directly, sck is high only while cs_n is low, and cs_n rises in the cycle after a push that starts no new word.
- R10: A word of N bits gives exactly N sck rising edges, and its push comes 2 * N * (prescale + 1) cycles after its pop.
- R11: busy is 1 from the cycle after the pop up to and including the push cycle, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows new words to start |
| loopback | input | 1 | Route transmit bits internally to the receiver |
| slave_req | input | 1 | Request for slave operation (unsupported, flagged) |
| word_bits_m1 | input | CNT_W (4) | Word size minus one |
| prescale | input | PRESC_W (8) | Half-period of sck minus one, in clocks |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_data | input | WORD_W (16) | Head of transmit FIFO |
| tx_pop | output | 1 | Consume the transmit FIFO head this cycle |
| rx_level | input | LVL_W (4) | Entries held in the receive FIFO |
| rx_push | output | 1 | Write rx_data into the receive FIFO this cycle |
| rx_data | output | WORD_W (16) | Received word, masked to the word size |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | A word is in flight |
| mode_err | output | 1 | Slave operation was requested while enabled |

## Verification
The bench fills the receive side without draining it until the engine stalls. The aim is to catch a start that ignores the push landing in the same cycle: such a design would push a ninth entry into a full FIFO. It runs one-bit words and sixteen-bit words at several prescales. An off-by-one in the half-period counter or the bit counter shows up there as a wrong count of rising edges or a push that arrives a cycle early or late. It runs back-to-back bursts to catch a chip select that bounces between words, and loopback words to catch a design that still toggles the pins or returns unmasked data. Disabled and slave-request phases leave words queued, and a design that leaked a start there would pop them.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } eng_state_t;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } half_t;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               half_done
);

  logic [PRESC_W-1:0] hcnt_q;

  assign half_done = run && (hcnt_q == presc);

  always_ff @(posedge clk) begin
    if (rst || !run || half_done) begin
      hcnt_q <= '0;
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_len_m1,
  input  logic              load_lb,
  input  logic              lb,
  input  logic [CNT_W-1:0]  len_m1,
  input  logic [CNT_W-1:0]  bit_idx,
  input  logic              rise,
  input  logic              fall,
  input  logic              last,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_data
);

  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic              mosi_q;
  logic [WORD_W-1:0] load_mask;
  logic [WORD_W-1:0] cur_mask;
  logic [CNT_W-1:0]  next_idx;

  // Masks built bit by bit so the size is a parameter, not a table.
  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      load_mask[i] = (CNT_W'(i) <= load_len_m1);
      cur_mask[i]  = (CNT_W'(i) <= len_m1);
    end
  end

  assign next_idx = bit_idx - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      mosi_q <= 1'b0;
    end else if (load) begin
      tx_q   <= load_word & load_mask;
      rx_q   <= '0;
      mosi_q <= load_lb ? 1'b0 : load_word[load_len_m1];
    end else begin
      if (rise) begin
        rx_q <= {rx_q[WORD_W-2:0], (lb ? tx_q[bit_idx] : miso)};
      end
      if (fall) begin
        mosi_q <= (last || lb) ? 1'b0 : tx_q[next_idx];
      end
    end
  end

  assign mosi    = mosi_q;
  assign rx_data = rx_q & cur_mask;

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int PRESC_W  = 8,
  parameter int RX_DEPTH = 8,
  localparam int CNT_W   = $clog2(WORD_W),
  localparam int LVL_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               loopback,
  input  logic               slave_req,
  input  logic [CNT_W-1:0]   word_bits_m1,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               tx_valid,
  input  logic [WORD_W-1:0]  tx_data,
  output logic               tx_pop,
  input  logic [LVL_W-1:0]   rx_level,
  output logic               rx_push,
  output logic [WORD_W-1:0]  rx_data,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic               cs_n,
  output logic               busy,
  output logic               mode_err
);

  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(RX_DEPTH);
  localparam logic [LVL_W-1:0] LVL_LAST = LVL_W'(RX_DEPTH - 1);

  eng_state_t         state_q;
  half_t              ph_q;
  logic [CNT_W-1:0]   bit_idx_q;
  logic [CNT_W-1:0]   len_q;
  logic               lb_q;
  logic [PRESC_W-1:0] presc_q;
  logic               mode_err_q;

  logic run, half_done, rise_ev, fall_ev, last_ev;
  logic start_ok, idle_start, cont_start, pop;

  assign run = (state_q == ST_RUN);

  spi_half_timer #(.PRESC_W(PRESC_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .presc     (presc_q),
    .half_done (half_done)
  );

  assign rise_ev = half_done && (ph_q == PH_LOW);
  assign fall_ev = half_done && (ph_q == PH_HIGH);
  assign last_ev = fall_ev && (bit_idx_q == '0);

  // A start that coincides with a push must leave room for that push.
  assign start_ok   = enable && !slave_req && tx_valid;
  assign idle_start = !run && start_ok && (rx_level < LVL_FULL);
  assign cont_start = last_ev && start_ok && (rx_level < LVL_LAST);
  assign pop        = idle_start || cont_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ph_q       <= PH_LOW;
      bit_idx_q  <= '0;
      len_q      <= '0;
      lb_q       <= 1'b0;
      presc_q    <= '0;
      mode_err_q <= 1'b0;
    end else begin
      mode_err_q <= enable && slave_req;
      if (pop) begin
        state_q   <= ST_RUN;
        ph_q      <= PH_LOW;
        bit_idx_q <= word_bits_m1;
        len_q     <= word_bits_m1;
        lb_q      <= loopback;
        presc_q   <= prescale;
      end else if (last_ev) begin
        state_q <= ST_IDLE;
        ph_q    <= PH_LOW;
      end else if (rise_ev) begin
        ph_q <= PH_HIGH;
      end else if (fall_ev) begin
        ph_q      <= PH_LOW;
        bit_idx_q <= bit_idx_q - 1'b1;
      end
    end
  end

  spi_bit_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .load        (pop),
    .load_word   (tx_data),
    .load_len_m1 (word_bits_m1),
    .load_lb     (loopback),
    .lb          (lb_q),
    .len_m1      (len_q),
    .bit_idx     (bit_idx_q),
    .rise        (rise_ev),
    .fall        (fall_ev),
    .last        (last_ev),
    .miso        (miso),
    .mosi        (mosi),
    .rx_data     (rx_data)
  );

  assign tx_pop   = pop;
  assign rx_push  = last_ev;
  assign sck      = (ph_q == PH_HIGH) && !lb_q;
  assign cs_n     = !(run && !lb_q);
  assign busy     = run;
  assign mode_err = mode_err_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> (rx_level < LVL_FULL)); // R3
  AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!enable && !busy) |=> !busy); // R2
  AST_LB_PINS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busy && lb_q) |-> (!sck && cs_n && !mosi)); // R4
  AST_SCK_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    sck |-> !cs_n); // R9
  AST_SLAVE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (enable && slave_req) |=> mode_err); // R7
  AST_SLAVE_NO_START: assert property (@(posedge clk) disable iff (rst)
    (enable && slave_req && !busy) |=> !busy); // R7
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi)); // R8
  AST_PUSH_IN_WORD: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> busy); // R11

endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;

  localparam int RXD = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0, loopback = 1'b0, slave_req = 1'b0;
  logic [3:0]  word_bits_m1 = 4'd7;
  logic [7:0]  prescale = 8'd0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_data = '0;
  logic [3:0]  rx_level = '0;
  logic        miso = 1'b0;
  logic        tx_pop, rx_push, sck, mosi, cs_n, busy, mode_err;
  logic [15:0] rx_data;

  spi_xfer_engine u0 (
    .clk(clk), .rst(rst), .enable(enable), .loopback(loopback),
    .slave_req(slave_req), .word_bits_m1(word_bits_m1), .prescale(prescale),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
    .rx_level(rx_level), .rx_push(rx_push), .rx_data(rx_data),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy),
    .mode_err(mode_err)
  );

  always #5 clk = ~clk;

  // Settings written by the stimulus, applied to the pins by the monitor.
  logic n_en = 0, n_lb = 0, n_slv = 0, drain_en = 1;
  logic [3:0] n_len = 4'd7;
  logic [7:0] n_presc = 8'd0;

  logic [15:0] txq[$];
  logic [15:0] expq[$];
  int rx_cnt = 0, cycle = 0, checks = 0, fails = 0;
  bit pend_pop = 0, pend_push = 0, in_word = 0, prev_me = 0, prev_sck = 0;
  bit cur_lb = 0, r1_done = 0, finished = 0;
  int since = 0, rises = 0, cur_n = 8, cur_h = 1, nl_idx = 0, cur_widx = 0;
  logic [15:0] cur_tx = '0, cur_reply = '0;

  function automatic logic [15:0] reply(int k);
    int v;
    v = k * 40503 + 23100;
    return v[15:0] ^ 16'hC3A5;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // Behavioural reference: FIFOs as queues, slave as an indexed bit source.
  always @(negedge clk) begin
    bit exp_pop;
    cycle++;
    rst = (cycle <= 3);
    if (pend_pop) begin void'(txq.pop_front()); pend_pop = 0; end
    if (drain_en && rx_cnt > 0) rx_cnt--;
    if (pend_push) begin
      chk(rx_cnt < RXD, "R3 push into full rx fifo", rx_cnt, RXD - 1);
      rx_cnt++;
      pend_push = 0;
    end
    enable = n_en; loopback = n_lb; slave_req = n_slv;
    word_bits_m1 = n_len; prescale = n_presc;
    tx_valid = (txq.size() > 0);
    tx_data = tx_valid ? txq[0] : 16'h0;
    rx_level = 4'(rx_cnt);
    #1;
    if (!rst) begin
      if (!r1_done) begin
        r1_done = 1;
        chk(cs_n && !sck && !mosi && !busy && !tx_pop && !rx_push && !mode_err,
            "R1 reset state", {cs_n, sck, mosi, busy, tx_pop, rx_push, mode_err}, 7'b1000000);
      end
      if (in_word) since++;
      chk(busy == in_word, "R11 busy", busy, in_word);
      chk(cs_n == !(in_word && !cur_lb), "R9 cs_n", cs_n, !(in_word && !cur_lb));
      if (sck) chk(!cs_n, "R9 sck without cs", cs_n, 0);
      if (in_word && cur_lb) chk(!sck && !mosi, "R4 pins idle in loopback", {sck, mosi}, 0);
      if (!in_word) chk(!sck && !mosi, "R8 idle pins", {sck, mosi}, 0);
      chk(mode_err == prev_me, "R7 mode_err", mode_err, prev_me);
      exp_pop = enable && !slave_req && (txq.size() > 0) &&
                (in_word ? (rx_push && rx_cnt < RXD - 1) : (rx_cnt < RXD));
      if (!enable) chk(!tx_pop, "R2 pop while disabled", tx_pop, 0);
      else if (slave_req) chk(!tx_pop, "R7 pop in slave request", tx_pop, 0);
      else chk(tx_pop == exp_pop, "R3 start rule", tx_pop, exp_pop);
      if (rx_push) chk(in_word, "R6 push without pop", in_word, 1);
      if (sck && !prev_sck && in_word) begin
        chk(!cur_lb, "R4 sck rise in loopback", 1, 0);
        chk(mosi == cur_tx[cur_n - 1 - rises], "R8 mosi bit", mosi, cur_tx[cur_n - 1 - rises]);
        if (rises == 0) chk(since == cur_h + 1, "R9 cs lead", since, cur_h + 1);
        else chk(since == cur_h + 1 + 2 * rises * cur_h, "R8 half period", since,
                 cur_h + 1 + 2 * rises * cur_h);
        rises++;
        if (rises < cur_n) miso = cur_reply[cur_n - 1 - rises];
      end
      if (rx_push && in_word) begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(since == 2 * cur_n * cur_h, "R10 word length", since, 2 * cur_n * cur_h);
        chk(rises == (cur_lb ? 0 : cur_n), "R10 sck edges", rises, cur_lb ? 0 : cur_n);
        if (cur_lb) chk(rx_data == e, "R4 loopback data", rx_data, e);
        else if (cur_n < 16) chk(rx_data == e, "R5 masked data", rx_data, e);
        else chk(rx_data == e, "R6 ordered data", rx_data, e);
        in_word = 0;
        pend_push = 1;
      end
      if (tx_pop) begin
        int m;
        m = (1 << (int'(word_bits_m1) + 1)) - 1;
        in_word = 1; since = 0; rises = 0; pend_pop = 1;
        cur_tx = txq[0];
        cur_n = int'(word_bits_m1) + 1;
        cur_h = int'(prescale) + 1;
        cur_lb = loopback;
        if (cur_lb) expq.push_back(cur_tx & m[15:0]);
        else begin
          cur_widx = nl_idx;
          cur_reply = reply(nl_idx);
          expq.push_back(cur_reply & m[15:0]);
          nl_idx++;
          miso = cur_reply[cur_n - 1];
        end
      end
    end
    prev_sck = sck;
    prev_me = enable && slave_req;
    if (cycle > 150000) begin
      chk(0, "watchdog", cycle, 150000);
      report();
    end
  end

  task automatic step(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic cfg(int len, int presc, bit lb);
    n_len = 4'(len - 1); n_presc = 8'(presc); n_lb = lb;
  endtask

  task automatic load(int n, logic [15:0] seed);
    for (int i = 0; i < n; i++) txq.push_back(seed ^ 16'(i * 16'h1357));
  endtask

  task automatic wait_idle(string req);
    int t;
    t = 0;
    while ((txq.size() > 0 || in_word || pend_pop || pend_push || rx_cnt > 0) && t < 30000) begin
      step(1); t++;
    end
    chk(t < 30000, req, t, 0);
    step(2);
  endtask

  initial begin
    step(6);
    n_en = 1;
    cfg(8, 1, 0);  load(3, 16'hA55A);  wait_idle("R6 drain 8-bit");
    cfg(16, 0, 0); load(5, 16'hF00F);  wait_idle("R10 drain 16-bit");
    cfg(1, 3, 0);  load(4, 16'hFFFF);  wait_idle("R10 drain 1-bit");
    cfg(5, 2, 0);  load(4, 16'hFFE3);  wait_idle("R5 drain 5-bit");
    cfg(12, 1, 1); load(4, 16'hBEEF);  wait_idle("R4 drain loopback");
    // disabled: words stay queued
    n_en = 0; cfg(8, 0, 0); load(3, 16'h00C3); step(60);
    chk(txq.size() == 3, "R2 words kept", txq.size(), 3);
    chk(!busy && cs_n, "R2 no transfer", busy, 0);
    n_en = 1; wait_idle("R2 resume");
    // receive FIFO full: the engine must stall
    drain_en = 0; cfg(4, 0, 0); load(11, 16'h5A5A); step(300);
    chk(rx_cnt == RXD, "R3 rx level at stall", rx_cnt, RXD);
    chk(txq.size() == 3, "R3 words held back", txq.size(), 3);
    chk(!busy && cs_n, "R3 stalled idle", busy, 0);
    drain_en = 1; wait_idle("R3 resume");
    // slave request: flagged, nothing moves
    n_slv = 1; load(2, 16'h0F0F); step(40);
    chk(mode_err, "R7 mode_err raised", mode_err, 1);
    chk(txq.size() == 2, "R7 words kept", txq.size(), 2);
    n_slv = 0; step(2);
    chk(!mode_err, "R7 mode_err clears", mode_err, 0);
    wait_idle("R7 resume");
    report();
  end

endmodule